// File: doc/BRIEF.md
# DMA Channel Register File and Command Decoder

This block is the software-visible face of a multi-channel DMA controller. A simple 32-bit register bus (write strobe, address, write data, combinational read data) reaches a 64-byte window per channel plus three global registers. Each window exposes a status word, a write-only command register, a configuration word, a next-link pointer, and two read-only values reported by the transfer engine: the bytes still to move and the link address in use.

Writes to a channel's command register are one-shot: each bit written as 1 fires one action. The actions are enable or disable the channel, raise a software request, soft-reset the channel, drop a pending request, acknowledge the end or terminal-count flag, and suspend or resume. Set and clear actions come in pairs. The engine itself lies outside this block. It reports busy, end, error, terminal count and descriptor error per channel, and the block turns these into sticky flags and one-bit-per-channel summaries. From those flags it also drives an end interrupt and an error interrupt. A global bit picks whether each interrupt is a level or a one-cycle pulse.

Top module: `dma_chan_csr`

## Requirements
- R1: Channel n occupies addresses 0x40*n to 0x40*n+0x3f. Within that window the offsets are fixed. Engine bytes-remaining is read-only at 0x20, and the engine current-link address is read-only at 0x3c. The configuration register at 0x2c and the next-link register at 0x38 are read/write. The `linkMode` output for a channel equals its configuration bit 31, and the `nextLink` output slice equals its next-link register.
- R2: The status register sits at offset 0x24. Bit 0 is enabled, bit 2 is transfer active, bit 4 is error, bit 5 is end, bit 6 is terminal count, and bit 10 is descriptor error. All other bits read 0. Writing 1 to command bit 0 (offset 0x28) sets the enable, and writing 1 to command bit 1 clears it. `chanEnable[n]` follows the enable. After reset every status bit is 0.
- R3: A write that carries both halves of a set/clear pair gives the clear. This covers bits 0 and 1 (enable) and bits 8 and 9 (suspend), so enable and `chanSuspend` end up 0.
- R4: The command register always reads 0. Command bits 7 and 10 to 31 have no effect on status, suspend or request.
- R5: Command bit 2 raises `swReq[n]`. Command bit 4 drops it, and so does an engine end on that channel.
- R6: An engine end pulse sets status bit 5 and bit n of the end summary at 0x318. Command bit 5 clears both. An engine terminal-count pulse sets status bit 6, and command bit 6 clears it.
- R7: An engine error pulse sets status bit 4 and clears the enable. An engine descriptor-error pulse sets status bit 10. Either one sets bit n of the error summary at 0x314.
- R8: Status bit 2 equals the channel's engine busy input as it was one clock earlier. After a disable and engine idle, command bit 3 clears enable, error, end, terminal count, descriptor error, request and suspend, and leaves configuration and next-link unchanged.
- R9: The global control register at 0x300 holds two bits that read back. Bit 0 drives `arbRoundRobin` (1 = round robin, 0 = fixed priority). Bit 1 selects level (1) or pulse (0) interrupt signalling.
- R10: In level mode, `endIrq` is high one clock after any channel has end set without configuration bit 24, or terminal count set without configuration bit 25. In level mode, `errIrq` is high one clock after any error-summary bit is set.
- R11: In pulse mode, each interrupt is high for exactly one clock, one clock after a new source bit rises.
- R12: Windows of channels at or above the channel count read 0 and ignore writes. Every other address without a register also reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Byte address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational on regAddr |
| engBusy | input | NCH | Engine transfer active per channel |
| engEnd | input | NCH | Engine end pulse per channel |
| engErr | input | NCH | Engine error pulse per channel |
| engTc | input | NCH | Engine terminal-count pulse per channel |
| engDescErr | input | NCH | Engine descriptor-error pulse per channel |
| engResidue | input | 32*NCH | Bytes remaining, packed per channel |
| engCurLink | input | 32*NCH | Current link address, packed per channel |
| chanEnable | output | NCH | Channel enabled |
| chanSuspend | output | NCH | Channel suspended |
| swReq | output | NCH | Pending software request |
| linkMode | output | NCH | Link mode selected per channel |
| nextLink | output | 32*NCH | Next-link pointers, packed per channel |
| arbRoundRobin | output | 1 | Channel arbitration is round robin |
| endIrq | output | 1 | End interrupt |
| errIrq | output | 1 | Error interrupt |

## Verification
The assertions assume that software does not acknowledge a flag in the same clock that the engine raises it. In that clock the engine event wins, so an assertion about a clear holds only when the engine pulse is absent. The assertions also assume that every engine report is a single-cycle pulse. The directed stimulus raises engine pulses only on clocks with no register write, and it returns each affected channel to idle with a soft reset before the next scenario. That keeps every interrupt check free of leftover sources.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 12;
  localparam int WIN_W  = ADDR_W - 6;

  localparam logic [5:0] OFS_RESIDUE = 6'h20;
  localparam logic [5:0] OFS_STATUS  = 6'h24;
  localparam logic [5:0] OFS_CMD     = 6'h28;
  localparam logic [5:0] OFS_CFG     = 6'h2c;
  localparam logic [5:0] OFS_NEXT    = 6'h38;
  localparam logic [5:0] OFS_CUR     = 6'h3c;

  localparam logic [ADDR_W-1:0] ADR_GCTL   = 12'h300;
  localparam logic [ADDR_W-1:0] ADR_ERRSUM = 12'h314;
  localparam logic [ADDR_W-1:0] ADR_ENDSUM = 12'h318;

  // command bit positions
  localparam int CB_SET_EN  = 0;
  localparam int CB_CLR_EN  = 1;
  localparam int CB_TRIG    = 2;
  localparam int CB_RESET   = 3;
  localparam int CB_CLR_REQ = 4;
  localparam int CB_CLR_END = 5;
  localparam int CB_CLR_TC  = 6;
  localparam int CB_SET_SUS = 8;
  localparam int CB_CLR_SUS = 9;

  // status bit positions
  localparam int SB_EN  = 0;
  localparam int SB_ACT = 2;
  localparam int SB_ERR = 4;
  localparam int SB_END = 5;
  localparam int SB_TC  = 6;
  localparam int SB_DER = 10;

  // configuration bit positions
  localparam int CF_END_MASK = 24;
  localparam int CF_TC_MASK  = 25;
  localparam int CF_LINK     = 31;

  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic trig;
    logic swRst;
    logic clrReq;
    logic clrEnd;
    logic clrTc;
    logic setSus;
    logic clrSus;
    logic wrCfg;
    logic wrNext;
  } chanCmd_t;

  typedef enum logic [2:0] {
    RS_NONE, RS_RESIDUE, RS_STATUS, RS_CFG, RS_NEXT, RS_CUR
  } rdSel_t;
endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [REG_W-1:0]      regWrData,
  output logic [REG_W-1:0]      regRdData,
  output chanCmd_t              cmd [NCH],
  output logic [CH_W-1:0]       rdChan,
  output rdSel_t                rdSel,
  input  logic [REG_W-1:0]      chanRdData,
  input  logic [NCH-1:0]        endSrc,
  input  logic [NCH-1:0]        errSumm,
  input  logic [NCH-1:0]        endSumm,
  output logic                  arbRoundRobin,
  output logic                  irqLevel,
  output logic                  endIrq,
  output logic                  errIrq
);
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int PAD_W = REG_W - NCH;

  logic [WIN_W-1:0] winIdx;
  logic [5:0]       ofs;
  logic             chHit;
  logic [1:0]       gctl;
  logic [NCH-1:0]   endSrcQ;
  logic [NCH-1:0]   errSrcQ;

  assign winIdx = regAddr[ADDR_W-1:6];
  assign ofs    = regAddr[5:0];
  assign chHit  = (winIdx < WIN_W'(NCH));
  assign rdChan = winIdx[CH_W-1:0];

  always_comb begin
    rdSel = RS_NONE;
    if (chHit) begin
      case (ofs)
        OFS_RESIDUE: rdSel = RS_RESIDUE;
        OFS_STATUS:  rdSel = RS_STATUS;
        OFS_CFG:     rdSel = RS_CFG;
        OFS_NEXT:    rdSel = RS_NEXT;
        OFS_CUR:     rdSel = RS_CUR;
        default:     rdSel = RS_NONE;
      endcase
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      cmd[c] = '0;
      if (regWrEn && chHit && (winIdx == WIN_W'(c))) begin
        if (ofs == OFS_CMD) begin
          cmd[c].setEn  = regWrData[CB_SET_EN];
          cmd[c].clrEn  = regWrData[CB_CLR_EN];
          cmd[c].trig   = regWrData[CB_TRIG];
          cmd[c].swRst  = regWrData[CB_RESET];
          cmd[c].clrReq = regWrData[CB_CLR_REQ];
          cmd[c].clrEnd = regWrData[CB_CLR_END];
          cmd[c].clrTc  = regWrData[CB_CLR_TC];
          cmd[c].setSus = regWrData[CB_SET_SUS];
          cmd[c].clrSus = regWrData[CB_CLR_SUS];
        end
        cmd[c].wrCfg  = (ofs == OFS_CFG);
        cmd[c].wrNext = (ofs == OFS_NEXT);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gctl <= '0;
    end else if (regWrEn && (regAddr == ADR_GCTL)) begin
      gctl <= regWrData[1:0];
    end
  end

  assign arbRoundRobin = gctl[0];
  assign irqLevel      = gctl[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      endSrcQ <= '0;
      errSrcQ <= '0;
      endIrq  <= 1'b0;
      errIrq  <= 1'b0;
    end else begin
      endSrcQ <= endSrc;
      errSrcQ <= errSumm;
      endIrq  <= irqLevel ? |endSrc  : |(endSrc & ~endSrcQ);
      errIrq  <= irqLevel ? |errSumm : |(errSumm & ~errSrcQ);
    end
  end

  always_comb begin
    case (regAddr)
      ADR_GCTL:   regRdData = {{(REG_W-2){1'b0}}, gctl};
      ADR_ERRSUM: regRdData = {{PAD_W{1'b0}}, errSumm};
      ADR_ENDSUM: regRdData = {{PAD_W{1'b0}}, endSumm};
      default:    regRdData = (rdSel != RS_NONE) ? chanRdData : '0;
    endcase
  end
endmodule

// File: rtl/dma_csr_datapath.sv
module dma_csr_datapath
  import dma_csr_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  chanCmd_t              cmd [NCH],
  input  logic [REG_W-1:0]      wrData,
  input  logic [CH_W-1:0]       rdChan,
  input  rdSel_t                rdSel,
  output logic [REG_W-1:0]      chanRdData,
  input  logic [NCH-1:0]        engBusy,
  input  logic [NCH-1:0]        engEnd,
  input  logic [NCH-1:0]        engErr,
  input  logic [NCH-1:0]        engTc,
  input  logic [NCH-1:0]        engDescErr,
  input  logic [REG_W*NCH-1:0]  engResidue,
  input  logic [REG_W*NCH-1:0]  engCurLink,
  output logic [NCH-1:0]        endSumm,
  output logic [NCH-1:0]        errSumm,
  output logic [NCH-1:0]        endSrc,
  output logic [NCH-1:0]        chanEnable,
  output logic [NCH-1:0]        chanSuspend,
  output logic [NCH-1:0]        swReq,
  output logic [NCH-1:0]        linkMode,
  output logic [REG_W*NCH-1:0]  nextLink
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [REG_W-1:0] statusArr [NCH];
  logic [REG_W-1:0] cfgArr    [NCH];
  logic [REG_W-1:0] nxtArr    [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic en, sus, req, act, err, endF, tc, der;
    logic [REG_W-1:0] cfg, nxt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        en <= 1'b0; sus <= 1'b0; req <= 1'b0; act <= 1'b0;
        err <= 1'b0; endF <= 1'b0; tc <= 1'b0; der <= 1'b0;
      end else if (cmd[c].swRst) begin
        en <= 1'b0; sus <= 1'b0; req <= 1'b0; act <= 1'b0;
        err <= 1'b0; endF <= 1'b0; tc <= 1'b0; der <= 1'b0;
      end else begin
        act <= engBusy[c];
        if (cmd[c].clrEn || engErr[c]) en <= 1'b0;
        else if (cmd[c].setEn)         en <= 1'b1;
        if (cmd[c].clrSus)             sus <= 1'b0;
        else if (cmd[c].setSus)        sus <= 1'b1;
        if (cmd[c].clrReq || engEnd[c]) req <= 1'b0;
        else if (cmd[c].trig)           req <= 1'b1;
        if (engEnd[c])                 endF <= 1'b1;
        else if (cmd[c].clrEnd)        endF <= 1'b0;
        if (engTc[c])                  tc <= 1'b1;
        else if (cmd[c].clrTc)         tc <= 1'b0;
        if (engErr[c])                 err <= 1'b1;
        if (engDescErr[c])             der <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfg <= '0;
        nxt <= '0;
      end else begin
        if (cmd[c].wrCfg)  cfg <= wrData;
        if (cmd[c].wrNext) nxt <= wrData;
      end
    end

    always_comb begin
      statusArr[c]         = '0;
      statusArr[c][SB_EN]  = en;
      statusArr[c][SB_ACT] = act;
      statusArr[c][SB_ERR] = err;
      statusArr[c][SB_END] = endF;
      statusArr[c][SB_TC]  = tc;
      statusArr[c][SB_DER] = der;
    end

    assign cfgArr[c]      = cfg;
    assign nxtArr[c]      = nxt;
    assign endSumm[c]     = endF;
    assign errSumm[c]     = err | der;
    assign endSrc[c]      = (endF & ~cfg[CF_END_MASK]) | (tc & ~cfg[CF_TC_MASK]);
    assign chanEnable[c]  = en;
    assign chanSuspend[c] = sus;
    assign swReq[c]       = req;
    assign linkMode[c]    = cfg[CF_LINK];
    assign nextLink[c*REG_W +: REG_W] = nxt;
  end

  always_comb begin
    case (rdSel)
      RS_RESIDUE: chanRdData = engResidue[int'(rdChan)*REG_W +: REG_W];
      RS_STATUS:  chanRdData = statusArr[rdChan];
      RS_CFG:     chanRdData = cfgArr[rdChan];
      RS_NEXT:    chanRdData = nxtArr[rdChan];
      RS_CUR:     chanRdData = engCurLink[int'(rdChan)*REG_W +: REG_W];
      default:    chanRdData = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [REG_W-1:0]      regWrData,
  output logic [REG_W-1:0]      regRdData,
  input  logic [NCH-1:0]        engBusy,
  input  logic [NCH-1:0]        engEnd,
  input  logic [NCH-1:0]        engErr,
  input  logic [NCH-1:0]        engTc,
  input  logic [NCH-1:0]        engDescErr,
  input  logic [REG_W*NCH-1:0]  engResidue,
  input  logic [REG_W*NCH-1:0]  engCurLink,
  output logic [NCH-1:0]        chanEnable,
  output logic [NCH-1:0]        chanSuspend,
  output logic [NCH-1:0]        swReq,
  output logic [NCH-1:0]        linkMode,
  output logic [REG_W*NCH-1:0]  nextLink,
  output logic                  arbRoundRobin,
  output logic                  endIrq,
  output logic                  errIrq
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  chanCmd_t         cmd [NCH];
  logic [CH_W-1:0]  rdChan;
  rdSel_t           rdSel;
  logic [REG_W-1:0] chanRdData;
  logic [NCH-1:0]   endSrc;
  logic [NCH-1:0]   endSumm;
  logic [NCH-1:0]   errSumm;
  logic             irqLevel;

  dma_csr_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cmd(cmd),
    .rdChan(rdChan), .rdSel(rdSel), .chanRdData(chanRdData),
    .endSrc(endSrc), .errSumm(errSumm), .endSumm(endSumm),
    .arbRoundRobin(arbRoundRobin), .irqLevel(irqLevel),
    .endIrq(endIrq), .errIrq(errIrq)
  );

  dma_csr_datapath #(.NCH(NCH)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(regWrData),
    .rdChan(rdChan), .rdSel(rdSel), .chanRdData(chanRdData),
    .engBusy(engBusy), .engEnd(engEnd), .engErr(engErr), .engTc(engTc),
    .engDescErr(engDescErr), .engResidue(engResidue),
    .engCurLink(engCurLink), .endSumm(endSumm), .errSumm(errSumm),
    .endSrc(endSrc), .chanEnable(chanEnable), .chanSuspend(chanSuspend),
    .swReq(swReq), .linkMode(linkMode), .nextLink(nextLink)
  );
endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk #(
  parameter int NCH = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            regWrEn,
  input logic [11:0]     regAddr,
  input logic [31:0]     regWrData,
  input logic [31:0]     regRdData,
  input logic [NCH-1:0]  engEnd,
  input logic [NCH-1:0]  chanEnable,
  input logic [NCH-1:0]  chanSuspend,
  input logic [NCH-1:0]  swReq,
  input logic [NCH-1:0]  endSumm,
  input logic [NCH-1:0]  errSumm,
  input logic            irqLevel,
  input logic            errIrq
);
  assert_cmd_reads_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[5:0] == 6'h28 && int'(regAddr[11:6]) < NCH) |-> regRdData == 32'h0);

  assert_unimpl_reads_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    (int'(regAddr[11:6]) >= NCH && int'(regAddr[11:6]) < 12) |-> regRdData == 32'h0);

  assert_level_err_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqLevel |=> (errIrq == $past(|errSumm)));

  assert_pulse_err_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    (errIrq && !$past(irqLevel)) |-> $past(|errSumm));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    localparam logic [11:0] CMD_ADR = 12'(c * 64 + 40);

    assert_enable_clear_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == CMD_ADR && regWrData[0] && regWrData[1]) |=> !chanEnable[c]);

    assert_suspend_clear_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == CMD_ADR && regWrData[8] && regWrData[9]) |=> !chanSuspend[c]);

    assert_soft_reset_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == CMD_ADR && regWrData[3])
        |=> (!chanEnable[c] && !chanSuspend[c] && !swReq[c] && !errSumm[c]));

    assert_clear_end_R6: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == CMD_ADR && regWrData[5] && !engEnd[c]) |=> !endSumm[c]);
  end
endmodule

bind dma_chan_csr dma_chan_csr_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/dma_chan_csr_tb.sv
`timescale 1ns/1ps
module dma_chan_csr_tb;
  localparam int NCH = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [11:0]       regAddr = '0;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;
  logic [NCH-1:0]    engBusy = '0, engEnd = '0, engErr = '0, engTc = '0, engDescErr = '0;
  logic [32*NCH-1:0] engResidue = '0, engCurLink = '0;
  logic [NCH-1:0]    chanEnable, chanSuspend, swReq, linkMode;
  logic [32*NCH-1:0] nextLink;
  logic              arbRoundRobin, endIrq, errIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_chan_csr #(.NCH(NCH)) u_dut (.*);

  function automatic logic [11:0] ca(int ch, int ofs);
    return 12'(ch * 64 + ofs);
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // kind: 0 end, 1 error, 2 terminal count, 3 descriptor error
  task automatic engPulse(int kind, int ch);
    @(negedge clk);
    case (kind)
      0: engEnd[ch] = 1'b1;
      1: engErr[ch] = 1'b1;
      2: engTc[ch] = 1'b1;
      default: engDescErr[ch] = 1'b1;
    endcase
    @(negedge clk);
    engEnd = '0; engErr = '0; engTc = '0; engDescErr = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int c = 0; c < NCH; c++) begin
      rd(ca(c, 'h24), d); chk("R2", "reset status", d, 0);
    end
    rd(12'h314, d); chk("R7", "reset error summary", d, 0);
    rd(12'h318, d); chk("R6", "reset end summary", d, 0);
    chk("R10", "reset irqs", {30'b0, endIrq, errIrq}, 0);
    chk("R2", "reset chanEnable", 32'(chanEnable), 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(ca(2, 'h2c), 32'h8000_0011);
    rd(ca(2, 'h2c), d); chk("R1", "cfg readback", d, 32'h8000_0011);
    chk("R1", "linkMode", 32'(linkMode), 32'h4);
    wr(ca(2, 'h38), 32'h1234_5670);
    rd(ca(2, 'h38), d); chk("R1", "next readback", d, 32'h1234_5670);
    chk("R1", "nextLink out", nextLink[95:64], 32'h1234_5670);
    rd(ca(0, 'h38), d); chk("R1", "other next untouched", d, 0);
    engResidue[95:64] = 32'h0000_abcd;
    engCurLink[63:32] = 32'h5555_aaaa;
    rd(ca(2, 'h20), d); chk("R1", "residue", d, 32'h0000_abcd);
    rd(ca(1, 'h3c), d); chk("R1", "current link", d, 32'h5555_aaaa);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(ca(1, 'h28), 32'h1);
    rd(ca(1, 'h24), d); chk("R2", "status after set enable", d, 32'h1);
    chk("R2", "chanEnable after set", 32'(chanEnable), 32'h2);
    wr(ca(1, 'h28), 32'h2);
    rd(ca(1, 'h24), d); chk("R2", "status after clear enable", d, 0);
    chk("R2", "chanEnable after clear", 32'(chanEnable), 0);
  endtask

  task automatic t_priority;
    wr(ca(0, 'h28), 32'h1);
    wr(ca(0, 'h28), 32'h3);
    chk("R3", "enable set+clear", 32'(chanEnable), 0);
    wr(ca(0, 'h28), 32'h100);
    chk("R3", "suspend set", 32'(chanSuspend), 32'h1);
    wr(ca(0, 'h28), 32'h300);
    chk("R3", "suspend set+clear", 32'(chanSuspend), 0);
  endtask

  task automatic t_undefined;
    logic [31:0] d;
    wr(ca(2, 'h28), 32'h1);
    wr(ca(2, 'h28), 32'h100);
    wr(ca(2, 'h28), 32'hffff_fc80);
    rd(ca(2, 'h24), d); chk("R4", "status after undefined bits", d, 32'h1);
    chk("R4", "suspend after undefined bits", 32'(chanSuspend), 32'h4);
    chk("R4", "request after undefined bits", 32'(swReq), 0);
    rd(ca(2, 'h28), d); chk("R4", "command reads zero", d, 0);
    wr(ca(2, 'h28), 32'h8);
  endtask

  task automatic t_request;
    wr(ca(3, 'h28), 32'h4);
    chk("R5", "trigger raises request", 32'(swReq), 32'h8);
    wr(ca(3, 'h28), 32'h10);
    chk("R5", "clear request", 32'(swReq), 0);
    wr(ca(3, 'h28), 32'h4);
    engPulse(0, 3);
    chk("R5", "engine end drops request", 32'(swReq), 0);
    wr(ca(3, 'h28), 32'h8);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_end_pulse;
    logic [31:0] d;
    engPulse(0, 2);
    chk("R11", "no irq before register stage", 32'(endIrq), 0);
    @(negedge clk);
    chk("R11", "end pulse high", 32'(endIrq), 1);
    @(negedge clk);
    chk("R11", "end pulse one cycle", 32'(endIrq), 0);
    rd(ca(2, 'h24), d); chk("R6", "status end", d, 32'h20);
    rd(12'h318, d); chk("R6", "end summary", d, 32'h4);
    wr(ca(2, 'h28), 32'h20);
    rd(12'h318, d); chk("R6", "end summary cleared", d, 0);
    rd(ca(2, 'h24), d); chk("R6", "status end cleared", d, 0);
    engPulse(2, 2);
    rd(ca(2, 'h24), d); chk("R6", "status tc", d, 32'h40);
    wr(ca(2, 'h28), 32'h40);
    rd(ca(2, 'h24), d); chk("R6", "status tc cleared", d, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_global;
    logic [31:0] d;
    wr(12'h300, 32'h1);
    chk("R9", "round robin out", 32'(arbRoundRobin), 1);
    rd(12'h300, d); chk("R9", "gctl readback 1", d, 32'h1);
    wr(12'h300, 32'hffff_fff3);
    rd(12'h300, d); chk("R9", "gctl readback 3", d, 32'h3);
    wr(12'h300, 32'h0);
    chk("R9", "fixed priority out", 32'(arbRoundRobin), 0);
  endtask

  task automatic t_error;
    logic [31:0] d;
    wr(12'h300, 32'h2);
    wr(ca(1, 'h28), 32'h1);
    engPulse(1, 1);
    @(negedge clk);
    chk("R10", "level err irq", 32'(errIrq), 1);
    repeat (3) @(negedge clk);
    chk("R10", "level err irq held", 32'(errIrq), 1);
    rd(ca(1, 'h24), d); chk("R7", "error status drops enable", d, 32'h10);
    rd(12'h314, d); chk("R7", "error summary", d, 32'h2);
    wr(ca(1, 'h28), 32'h8);
    @(negedge clk);
    chk("R10", "err irq after reset", 32'(errIrq), 0);
    engPulse(3, 0);
    rd(ca(0, 'h24), d); chk("R7", "descriptor error status", d, 32'h400);
    rd(12'h314, d); chk("R7", "descriptor error summary", d, 32'h1);
    wr(ca(0, 'h28), 32'h8);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(ca(3, 'h2c), 32'h0100_0000);
    engPulse(0, 3);
    rd(12'h318, d); chk("R6", "masked end summary", d, 32'h8);
    repeat (2) @(negedge clk);
    chk("R10", "masked end gives no irq", 32'(endIrq), 0);
    engPulse(2, 3);
    @(negedge clk);
    chk("R10", "unmasked tc irq", 32'(endIrq), 1);
    wr(ca(3, 'h28), 32'h40);
    @(negedge clk);
    chk("R10", "tc cleared irq low", 32'(endIrq), 0);
    wr(ca(3, 'h28), 32'h8);
    rd(ca(3, 'h2c), d); chk("R8", "cfg kept over reset", d, 32'h0100_0000);
  endtask

  task automatic t_active;
    logic [31:0] d;
    wr(ca(0, 'h28), 32'h1);
    @(negedge clk); engBusy[0] = 1'b1;
    rd(ca(0, 'h24), d); chk("R8", "active while busy", d, 32'h5);
    wr(ca(0, 'h28), 32'h2);
    rd(ca(0, 'h24), d); chk("R8", "disabled still active", d, 32'h4);
    @(negedge clk); engBusy[0] = 1'b0;
    rd(ca(0, 'h24), d); chk("R8", "active drops", d, 0);
    engPulse(2, 0);
    wr(ca(0, 'h28), 32'h104);
    wr(ca(0, 'h28), 32'h8);
    rd(ca(0, 'h24), d); chk("R8", "status after soft reset", d, 0);
    chk("R8", "suspend+request after reset", {chanSuspend, swReq}, 0);
  endtask

  task automatic t_unimpl;
    logic [31:0] d;
    wr(12'h128, 32'h1);
    wr(12'h12c, 32'hff);
    rd(12'h12c, d); chk("R12", "unimplemented cfg", d, 0);
    rd(12'h124, d); chk("R12", "unimplemented status", d, 0);
    chk("R12", "no channel enabled", 32'(chanEnable), 0);
    rd(12'h200, d); chk("R12", "hole 0x200", d, 0);
    rd(12'h3fc, d); chk("R12", "hole 0x3fc", d, 0);
    rd(ca(1, 'h00), d); chk("R12", "channel unused offset", d, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_enable();
    t_priority();
    t_undefined();
    t_request();
    t_end_pulse();
    t_global();
    t_error();
    t_mask();
    t_active();
    t_unimpl();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule